// File: doc/BRIEF.md
# Bidirectional Dual-Clock FIFO with Mailbox Bypass

This block joins two ports, A and B, that run on independent free-running clocks. The clocks may be unrelated or identical. Two first-in first-out queues of 36-bit words run in opposite directions. The forward lane takes words written at port A and delivers them at port B. The return lane takes words written at port B and delivers them at port A. Each lane also has a one-word mailbox. A port uses the mailbox to pass a single urgent word past the queued traffic.

Each port has a select, an enable, a write/read direction bit and a mailbox bit. A transfer happens on the port's rising clock edge when select and enable are both high. The direction bit picks between writing the outbound lane and reading the inbound lane. The mailbox bit redirects that access to the mailbox instead of the queue.

Each port sees the flags that matter to it, in its own clock domain: input ready and almost-full for its outbound lane, and output ready and almost-empty for its inbound lane. Each lane has its own active-low reset, which clears that lane's queue and mailbox and nothing else. While a lane's reset is held, a two-bit threshold select is captured and sets that lane's almost-flag offset.

Top module: `bidir_fifo_mbox`

## Requirements
- R1: While a lane's reset is low, and right after it is released, the writing port sees input ready = 1, almost-full = 0 and mailbox busy = 0. The reading port sees output ready = 0, almost-empty = 1 and mailbox available = 0, and that port's read data register is 0.
- R2: Words accepted at port A (select = 1, enable = 1, write bit = 1, mailbox bit = 0, input ready = 1) leave port B in the same order with the same value.
  - Port B reads them with select = 1, enable = 1, write bit = 0, mailbox bit = 0 and output ready = 1.
  - The word is in `b_rdata` after the read edge.
- R3: Words accepted at port B leave port A in the same order with the same value, under the same rules with the roles of the ports swapped.
- R4: A port makes no transfer on an edge where select or enable is low.
- R5: After DEPTH unread words, input ready goes low and further writes are dropped. After the reader drains the lane, input ready returns within a few writer cycles.
- R6: A queue read while output ready is low changes neither the read data nor the queue contents.
- R7: Almost-empty, in the reading domain, is 1 exactly when the number of stored words is at or below the lane's offset.
- R8: Almost-full, in the writing domain, is 1 exactly when the free space is at or below the lane's offset. Almost-full is therefore always 1 while input ready is 0.
- R9: The threshold select captured during a lane's reset maps to an offset in words: 0 gives 16, 1 gives 12, 2 gives 8, 3 gives 4.
- R10: Resetting one lane leaves the other lane's stored words, flags and offset untouched.
- R11: A write with the mailbox bit set stores the word in that direction's mailbox and never enters the queue.
  - Mailbox busy rises at the writer on the next edge.
  - Mailbox available rises at the reader after synchronization.
  - A read with the mailbox bit set returns the word and clears available at once; busy clears at the writer a few cycles later.
- R12: A mailbox write while mailbox busy is 1 is dropped; the word already held is the one delivered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a | input | 1 | Port A clock |
| clk_b | input | 1 | Port B clock |
| rst_ab_n | input | 1 | Active-low reset of the A-to-B lane and its mailbox |
| rst_ba_n | input | 1 | Active-low reset of the B-to-A lane and its mailbox |
| flag_sel | input | 2 | Threshold select, captured by a lane while its reset is low |
| a_sel | input | 1 | Port A select |
| a_en | input | 1 | Port A enable |
| a_wr | input | 1 | Port A direction: 1 write, 0 read |
| a_mb | input | 1 | Port A access targets the mailbox |
| a_wdata | input | WIDTH | Port A write word |
| a_rdata | output | WIDTH | Port A read word, registered |
| a_in_rdy | output | 1 | A-to-B lane can accept a word |
| a_out_rdy | output | 1 | B-to-A lane holds a word |
| a_afull | output | 1 | A-to-B lane almost full |
| a_aempty | output | 1 | B-to-A lane almost empty |
| a_mbox_busy | output | 1 | A-to-B mailbox still unread |
| a_mbox_avail | output | 1 | B-to-A mailbox holds a word |
| b_sel | input | 1 | Port B select |
| b_en | input | 1 | Port B enable |
| b_wr | input | 1 | Port B direction: 1 write, 0 read |
| b_mb | input | 1 | Port B access targets the mailbox |
| b_wdata | input | WIDTH | Port B write word |
| b_rdata | output | WIDTH | Port B read word, registered |
| b_in_rdy | output | 1 | B-to-A lane can accept a word |
| b_out_rdy | output | 1 | A-to-B lane holds a word |
| b_afull | output | 1 | B-to-A lane almost full |
| b_aempty | output | 1 | A-to-B lane almost empty |
| b_mbox_busy | output | 1 | B-to-A mailbox still unread |
| b_mbox_avail | output | 1 | A-to-B mailbox holds a word |

## Verification
The hardest case to reach is resetting one lane while the other lane holds data. It has to be shown that the surviving lane keeps its words and its old offset, while the reset lane picks up a new one. The stimulus first parks three words in the return lane under offset 8. It then pulses only the forward reset with the select changed to 3. Next it tops the return lane up to exactly eight and then nine words, checking that almost-empty still follows offset 8. The forward lane is then filled to four and five words to show that it now follows offset 4. Filling to one short of full, then full, then past full, with the mailbox exercised alongside, covers the remaining flag boundaries.

// File: rtl/bdf_pkg.sv
package bdf_pkg;

   typedef logic [8:0] offset_t;

   function automatic offset_t flag_offset(input logic [1:0] sel);
      offset_t v;
      case (sel)
         2'd0:    v = 9'd16;
         2'd1:    v = 9'd12;
         2'd2:    v = 9'd8;
         default: v = 9'd4;
      endcase
      return v;
   endfunction

endpackage

// File: rtl/bdf_sync.sv
module bdf_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] st [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) st[i] <= '0;
      end else begin
         st[0] <= d;
         for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
      end
   end

   assign q = st[STAGES-1];
endmodule

// File: rtl/bdf_lane.sv
module bdf_lane
   import bdf_pkg::*;
#(
   parameter int WIDTH       = 36,
   parameter int DEPTH       = 256,
   parameter int SYNC_STAGES = 2
) (
   input  logic             wclk,
   input  logic             rclk,
   input  logic             rst_n,
   input  logic [1:0]       flag_sel,
   input  logic             wr_req,
   input  logic [WIDTH-1:0] wdata,
   input  logic             rd_req,
   output logic [WIDTH-1:0] rd_word,
   output logic             rd_fire,
   output logic             in_rdy,
   output logic             afull,
   output logic             out_rdy,
   output logic             aempty
);
   localparam int AW = $clog2(DEPTH);
   localparam int PW = AW + 1;
   typedef logic [PW-1:0] ptr_t;

   function automatic ptr_t to_gray(input ptr_t b);
      return b ^ (b >> 1);
   endfunction

   function automatic ptr_t from_gray(input ptr_t g);
      ptr_t b;
      b[PW-1] = g[PW-1];
      for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
      return b;
   endfunction

   logic [WIDTH-1:0] mem [DEPTH];
   ptr_t    wbin, wgray, rbin, rgray;
   ptr_t    rgray_w, wgray_r, used_w, used_r;
   offset_t off_w, off_r;
   logic    wr_fire;

   // write domain
   assign wr_fire = wr_req & in_rdy;

   always_ff @(posedge wclk or negedge rst_n) begin
      if (!rst_n) begin
         wbin  <= '0;
         wgray <= '0;
      end else if (wr_fire) begin
         wbin  <= wbin + ptr_t'(1);
         wgray <= to_gray(wbin + ptr_t'(1));
      end
   end

   always_ff @(posedge wclk) begin
      if (wr_fire) mem[wbin[AW-1:0]] <= wdata;
   end

   always_ff @(posedge wclk) begin
      if (!rst_n) off_w <= flag_offset(flag_sel);
   end

   bdf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_rptr_sync (
      .clk(wclk), .rst_n(rst_n), .d(rgray), .q(rgray_w)
   );

   assign used_w = wbin - from_gray(rgray_w);
   assign in_rdy = (int'(used_w) != DEPTH);
   assign afull  = (DEPTH - int'(used_w)) <= int'(off_w);

   // read domain
   assign rd_fire = rd_req & out_rdy;
   assign rd_word = mem[rbin[AW-1:0]];

   always_ff @(posedge rclk or negedge rst_n) begin
      if (!rst_n) begin
         rbin  <= '0;
         rgray <= '0;
      end else if (rd_fire) begin
         rbin  <= rbin + ptr_t'(1);
         rgray <= to_gray(rbin + ptr_t'(1));
      end
   end

   always_ff @(posedge rclk) begin
      if (!rst_n) off_r <= flag_offset(flag_sel);
   end

   bdf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_wptr_sync (
      .clk(rclk), .rst_n(rst_n), .d(wgray), .q(wgray_r)
   );

   assign used_r  = from_gray(wgray_r) - rbin;
   assign out_rdy = (used_r != '0);
   assign aempty  = int'(used_r) <= int'(off_r);
endmodule

// File: rtl/bdf_mailbox.sv
module bdf_mailbox #(
   parameter int WIDTH       = 36,
   parameter int SYNC_STAGES = 2
) (
   input  logic             wclk,
   input  logic             rclk,
   input  logic             rst_n,
   input  logic             wr_req,
   input  logic [WIDTH-1:0] wdata,
   input  logic             rd_req,
   output logic             rd_fire,
   output logic             busy,
   output logic             avail,
   output logic [WIDTH-1:0] mail
);
   logic wtog, rtog, wtog_r, rtog_w, wr_fire;

   assign busy    = wtog ^ rtog_w;
   assign wr_fire = wr_req & ~busy;

   always_ff @(posedge wclk or negedge rst_n) begin
      if (!rst_n) begin
         wtog <= 1'b0;
         mail <= '0;
      end else if (wr_fire) begin
         wtog <= ~wtog;
         mail <= wdata;
      end
   end

   bdf_sync #(.W(1), .STAGES(SYNC_STAGES)) u_wtog_sync (
      .clk(rclk), .rst_n(rst_n), .d(wtog), .q(wtog_r)
   );

   assign avail   = wtog_r ^ rtog;
   assign rd_fire = rd_req & avail;

   always_ff @(posedge rclk or negedge rst_n) begin
      if (!rst_n)       rtog <= 1'b0;
      else if (rd_fire) rtog <= ~rtog;
   end

   bdf_sync #(.W(1), .STAGES(SYNC_STAGES)) u_rtog_sync (
      .clk(wclk), .rst_n(rst_n), .d(rtog), .q(rtog_w)
   );
endmodule

// File: rtl/bidir_fifo_mbox.sv
module bidir_fifo_mbox #(
   parameter int WIDTH       = 36,
   parameter int DEPTH       = 256,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk_a,
   input  logic             clk_b,
   input  logic             rst_ab_n,
   input  logic             rst_ba_n,
   input  logic [1:0]       flag_sel,
   input  logic             a_sel,
   input  logic             a_en,
   input  logic             a_wr,
   input  logic             a_mb,
   input  logic [WIDTH-1:0] a_wdata,
   output logic [WIDTH-1:0] a_rdata,
   output logic             a_in_rdy,
   output logic             a_out_rdy,
   output logic             a_afull,
   output logic             a_aempty,
   output logic             a_mbox_busy,
   output logic             a_mbox_avail,
   input  logic             b_sel,
   input  logic             b_en,
   input  logic             b_wr,
   input  logic             b_mb,
   input  logic [WIDTH-1:0] b_wdata,
   output logic [WIDTH-1:0] b_rdata,
   output logic             b_in_rdy,
   output logic             b_out_rdy,
   output logic             b_afull,
   output logic             b_aempty,
   output logic             b_mbox_busy,
   output logic             b_mbox_avail
);
   localparam int NPORT = 2;

   initial begin
      assert (WIDTH > 0) else $fatal(1, "WIDTH must be positive");
      assert (DEPTH >= 32 && (DEPTH & (DEPTH - 1)) == 0)
         else $fatal(1, "DEPTH must be a power of two, at least 32");
      assert (SYNC_STAGES >= 2) else $fatal(1, "SYNC_STAGES must be at least 2");
   end

   // index 0 = port A / lane A->B, index 1 = port B / lane B->A
   logic [NPORT-1:0] clk_v, rst_v;
   logic [NPORT-1:0] q_wr, q_rd, m_wr, m_rd;
   logic [WIDTH-1:0] wdata_v [NPORT];

   assign clk_v = {clk_b, clk_a};
   assign rst_v = {rst_ba_n, rst_ab_n};
   assign wdata_v[0] = a_wdata;
   assign wdata_v[1] = b_wdata;

   assign q_wr = {b_sel & b_en &  b_wr & ~b_mb, a_sel & a_en &  a_wr & ~a_mb};
   assign q_rd = {b_sel & b_en & ~b_wr & ~b_mb, a_sel & a_en & ~a_wr & ~a_mb};
   assign m_wr = {b_sel & b_en &  b_wr &  b_mb, a_sel & a_en &  a_wr &  a_mb};
   assign m_rd = {b_sel & b_en & ~b_wr &  b_mb, a_sel & a_en & ~a_wr &  a_mb};

   logic [NPORT-1:0] l_in_rdy, l_afull, l_out_rdy, l_aempty, l_rd_fire;
   logic [NPORT-1:0] mb_busy, mb_avail, mb_rd_fire;
   logic [WIDTH-1:0] l_word [NPORT];
   logic [WIDTH-1:0] mb_data [NPORT];

   for (genvar d = 0; d < NPORT; d++) begin : g_dir
      localparam int RP = NPORT - 1 - d;

      bdf_lane #(.WIDTH(WIDTH), .DEPTH(DEPTH), .SYNC_STAGES(SYNC_STAGES)) u_lane (
         .wclk     (clk_v[d]),
         .rclk     (clk_v[RP]),
         .rst_n    (rst_v[d]),
         .flag_sel (flag_sel),
         .wr_req   (q_wr[d]),
         .wdata    (wdata_v[d]),
         .rd_req   (q_rd[RP]),
         .rd_word  (l_word[d]),
         .rd_fire  (l_rd_fire[d]),
         .in_rdy   (l_in_rdy[d]),
         .afull    (l_afull[d]),
         .out_rdy  (l_out_rdy[d]),
         .aempty   (l_aempty[d])
      );

      bdf_mailbox #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) u_mbox (
         .wclk    (clk_v[d]),
         .rclk    (clk_v[RP]),
         .rst_n   (rst_v[d]),
         .wr_req  (m_wr[d]),
         .wdata   (wdata_v[d]),
         .rd_req  (m_rd[RP]),
         .rd_fire (mb_rd_fire[d]),
         .busy    (mb_busy[d]),
         .avail   (mb_avail[d]),
         .mail    (mb_data[d])
      );
   end

   for (genvar p = 0; p < NPORT; p++) begin : g_port
      localparam int IN = NPORT - 1 - p;
      logic [WIDTH-1:0] rdata_q;

      always_ff @(posedge clk_v[p] or negedge rst_v[IN]) begin
         if (!rst_v[IN])            rdata_q <= '0;
         else if (l_rd_fire[IN])    rdata_q <= l_word[IN];
         else if (mb_rd_fire[IN])   rdata_q <= mb_data[IN];
      end
   end

   assign a_rdata      = g_port[0].rdata_q;
   assign b_rdata      = g_port[1].rdata_q;
   assign a_in_rdy     = l_in_rdy[0];
   assign a_afull      = l_afull[0];
   assign a_out_rdy    = l_out_rdy[1];
   assign a_aempty     = l_aempty[1];
   assign a_mbox_busy  = mb_busy[0];
   assign a_mbox_avail = mb_avail[1];
   assign b_in_rdy     = l_in_rdy[1];
   assign b_afull      = l_afull[1];
   assign b_out_rdy    = l_out_rdy[0];
   assign b_aempty     = l_aempty[0];
   assign b_mbox_busy  = mb_busy[1];
   assign b_mbox_avail = mb_avail[0];
endmodule

// File: rtl/bidir_fifo_mbox_chk.sv
module bidir_fifo_mbox_chk #(
   parameter int WIDTH = 36
) (
   input logic             clk_a,
   input logic             clk_b,
   input logic             rst_ab_n,
   input logic             a_sel,
   input logic             a_en,
   input logic             a_wr,
   input logic             a_mb,
   input logic             a_in_rdy,
   input logic             a_afull,
   input logic             a_mbox_busy,
   input logic             b_sel,
   input logic             b_en,
   input logic             b_wr,
   input logic             b_mb,
   input logic [WIDTH-1:0] b_rdata,
   input logic             b_out_rdy,
   input logic             b_aempty,
   input logic             b_mbox_avail
);
   assert_reset_flags_R1: assert property (@(posedge clk_a)
      !rst_ab_n |-> (a_in_rdy && !a_mbox_busy));

   assert_empty_read_hold_R6: assert property (@(posedge clk_b) disable iff (!rst_ab_n)
      (b_sel && b_en && !b_wr && !b_mb && !b_out_rdy) |=> $stable(b_rdata));

   assert_empty_is_aempty_R7: assert property (@(posedge clk_b) disable iff (!rst_ab_n)
      !b_out_rdy |-> b_aempty);

   assert_full_is_afull_R8: assert property (@(posedge clk_a) disable iff (!rst_ab_n)
      !a_in_rdy |-> a_afull);

   assert_mbox_busy_set_R11: assert property (@(posedge clk_a) disable iff (!rst_ab_n)
      (a_sel && a_en && a_wr && a_mb && !a_mbox_busy) |=> a_mbox_busy);

   assert_mbox_avail_hold_R11: assert property (@(posedge clk_b) disable iff (!rst_ab_n)
      (b_mbox_avail && !(b_sel && b_en && !b_wr && b_mb)) |=> b_mbox_avail);
endmodule

bind bidir_fifo_mbox bidir_fifo_mbox_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/bidir_fifo_mbox_test.sv
module bidir_fifo_mbox_test;
   localparam int W = 36;
   localparam int D = 64;

   logic clk_a = 1'b0, clk_b = 1'b0;
   logic rst_ab_n = 1'b0, rst_ba_n = 1'b0;
   logic [1:0] flag_sel = 2'd2;
   logic a_sel = 0, a_en = 0, a_wr = 0, a_mb = 0;
   logic b_sel = 0, b_en = 0, b_wr = 0, b_mb = 0;
   logic [W-1:0] a_wdata = '0, b_wdata = '0;
   logic [W-1:0] a_rdata, b_rdata;
   logic a_in_rdy, a_out_rdy, a_afull, a_aempty, a_mbox_busy, a_mbox_avail;
   logic b_in_rdy, b_out_rdy, b_afull, b_aempty, b_mbox_busy, b_mbox_avail;

   int checks = 0, failures = 0;
   bit done = 0;
   logic [W-1:0] q_ab [$];
   logic [W-1:0] q_ba [$];

   always #10 clk_a = ~clk_a;
   always #13 clk_b = ~clk_b;

   bidir_fifo_mbox #(.WIDTH(W), .DEPTH(D), .SYNC_STAGES(2)) uut (.*);

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic a_put(input logic [W-1:0] d, input bit mb);
      @(negedge clk_a);
      a_sel = 1; a_en = 1; a_wr = 1; a_mb = mb; a_wdata = d;
      if (!mb && a_in_rdy) q_ab.push_back(d);
      @(negedge clk_a);
      a_sel = 0; a_en = 0; a_wr = 0; a_mb = 0;
   endtask

   task automatic b_put(input logic [W-1:0] d, input bit mb);
      @(negedge clk_b);
      b_sel = 1; b_en = 1; b_wr = 1; b_mb = mb; b_wdata = d;
      if (!mb && b_in_rdy) q_ba.push_back(d);
      @(negedge clk_b);
      b_sel = 0; b_en = 0; b_wr = 0; b_mb = 0;
   endtask

   // monitors: wait for data, read one word, compare with scoreboard head
   task automatic b_pop(input string req);
      @(negedge clk_b);
      while (!b_out_rdy) @(negedge clk_b);
      b_sel = 1; b_en = 1; b_wr = 0; b_mb = 0;
      @(negedge clk_b);
      b_sel = 0; b_en = 0;
      chk(req, 64'(b_rdata), (q_ab.size() > 0) ? 64'(q_ab.pop_front()) : 64'hDEAD);
   endtask

   task automatic a_pop(input string req);
      @(negedge clk_a);
      while (!a_out_rdy) @(negedge clk_a);
      a_sel = 1; a_en = 1; a_wr = 0; a_mb = 0;
      @(negedge clk_a);
      a_sel = 0; a_en = 0;
      chk(req, 64'(a_rdata), (q_ba.size() > 0) ? 64'(q_ba.pop_front()) : 64'hDEAD);
   endtask

   task automatic b_read_raw(input bit mb, input bit sel, input bit en);
      @(negedge clk_b);
      b_sel = sel; b_en = en; b_wr = 0; b_mb = mb;
      @(negedge clk_b);
      b_sel = 0; b_en = 0; b_mb = 0;
   endtask

   task automatic wait_a(input int n); repeat (n) @(negedge clk_a); endtask
   task automatic wait_b(input int n); repeat (n) @(negedge clk_b); endtask

   initial begin
      #2000000;
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [W-1:0] held;
      // reset both lanes with offset 8
      wait_b(4);
      chk("R1 a_in_rdy in reset", a_in_rdy, 1);
      chk("R1 b_out_rdy in reset", b_out_rdy, 0);
      rst_ab_n = 1; rst_ba_n = 1;
      wait_b(3);
      chk("R1 b flags", {b_in_rdy, b_out_rdy, b_afull, b_aempty, b_mbox_busy, b_mbox_avail}, 6'b100100);
      chk("R1 a flags", {a_in_rdy, a_out_rdy, a_afull, a_aempty, a_mbox_busy, a_mbox_avail}, 6'b100100);
      chk("R1 rdata", {a_rdata, b_rdata}, 0);

      // R4: no transfer without select and enable
      @(negedge clk_a); a_sel = 0; a_en = 1; a_wr = 1; a_wdata = 36'h111;
      @(negedge clk_a); a_sel = 1; a_en = 0;
      @(negedge clk_a); a_sel = 0; a_en = 0; a_wr = 0;
      wait_b(6);
      chk("R4 gated writes ignored", b_out_rdy, 0);

      // R7: eight words = offset -> almost-empty, nine -> not
      for (int i = 0; i < 8; i++) a_put(36'hA0000 + 36'(i), 0);
      wait_b(5);
      chk("R7 out_rdy", b_out_rdy, 1);
      chk("R7 aempty at 8", b_aempty, 1);
      a_put(36'hA0008, 0);
      wait_b(5);
      chk("R7 aempty at 9", b_aempty, 0);

      // R4: gated reads do not pop
      b_read_raw(0, 1, 0);
      b_read_raw(0, 0, 1);
      chk("R4 gated reads leave rdata", b_rdata, 0);

      // R2: drain in order
      for (int i = 0; i < 9; i++) b_pop("R2 A->B order");
      held = b_rdata;
      chk("R2 empty after drain", b_out_rdy, 0);
      // R6: read while empty
      b_read_raw(0, 1, 1);
      chk("R6 rdata held", b_rdata, held);
      a_put(36'hC0FFEE, 0);
      b_pop("R6 next word intact");

      // R3: B->A
      for (int i = 0; i < 5; i++) b_put(36'hB0000 + 36'(i * 7), 0);
      for (int i = 0; i < 5; i++) a_pop("R3 B->A order");

      // R8 / R5: fill forward lane
      for (int i = 0; i < D - 9; i++) a_put(36'h10000 + 36'(i), 0);
      chk("R8 afull at free 9", a_afull, 0);
      a_put(36'h1FFF0, 0);
      chk("R8 afull at free 8", a_afull, 1);
      for (int i = 0; i < 8; i++) a_put(36'h20000 + 36'(i), 0);
      chk("R5 in_rdy low when full", a_in_rdy, 0);
      chk("R5 accepted count", q_ab.size(), D);
      for (int i = 0; i < 3; i++) a_put(36'h3BAD0 + 36'(i), 0);
      for (int i = 0; i < D; i++) b_pop("R5 full drain order");
      wait_b(6);
      chk("R5 dropped writes absent", b_out_rdy, 0);
      wait_a(5);
      chk("R5 in_rdy recovers", a_in_rdy, 1);

      // R10 / R9: reset forward lane only, with offset 4
      for (int i = 0; i < 3; i++) b_put(36'h50000 + 36'(i), 0);
      wait_a(5);
      chk("R7 a_aempty at 3", a_aempty, 1);
      flag_sel = 2'd3;
      rst_ab_n = 0;
      wait_b(4);
      rst_ab_n = 1;
      wait_b(3);
      chk("R10 other lane kept", a_out_rdy, 1);
      for (int i = 3; i < 8; i++) b_put(36'h50000 + 36'(i), 0);
      wait_a(5);
      chk("R10 other offset kept at 8", a_aempty, 1);
      b_put(36'h50008, 0);
      wait_a(5);
      chk("R10 other lane aempty at 9", a_aempty, 0);
      for (int i = 0; i < 4; i++) a_put(36'h60000 + 36'(i), 0);
      wait_b(5);
      chk("R9 sel 3 aempty at 4", b_aempty, 1);
      a_put(36'h60004, 0);
      wait_b(5);
      chk("R9 sel 3 aempty at 5", b_aempty, 0);
      for (int i = 0; i < 5; i++) b_pop("R9 drain");
      for (int i = 0; i < 9; i++) a_pop("R10 drain kept lane");

      // R11 / R12: mailboxes
      a_put(36'h0AAAA1, 1);
      chk("R11 busy after write", a_mbox_busy, 1);
      wait_b(4);
      chk("R11 avail at reader", b_mbox_avail, 1);
      chk("R11 bypasses queue", b_out_rdy, 0);
      a_put(36'h0BBBB2, 1);
      b_read_raw(1, 1, 1);
      chk("R12 first mail delivered", b_rdata, 36'h0AAAA1);
      chk("R11 avail cleared", b_mbox_avail, 0);
      wait_a(5);
      chk("R11 busy cleared", a_mbox_busy, 0);
      wait_b(5);
      chk("R12 second mail dropped", b_mbox_avail, 0);
      b_put(36'h0CCCC3, 1);
      wait_a(4);
      chk("R11 B->A avail", a_mbox_avail, 1);
      @(negedge clk_a); a_sel = 1; a_en = 1; a_wr = 0; a_mb = 1;
      @(negedge clk_a); a_sel = 0; a_en = 0; a_mb = 0;
      chk("R11 B->A mail word", a_rdata, 36'h0CCCC3);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule